// File: doc/BRIEF.md
# Event Counter Bank with Privileged Read Port

This block holds a bank of event counters, each advancing by one in every clock cycle in which its own event line is high, and answers read requests that look like a processor instruction. A request carries a 32-bit select word and the caller's privilege context: the current privilege level, whether protection is active, and whether user-level reads are allowed. The unit answers one cycle later with a 32-bit low word and a 32-bit high word, or it reports a protection fault or an invalid-opcode fault.

The bank mixes two counter widths. The first eighteen counters are 40 bits wide and the last eight are 32 bits wide. The top bit of the select word asks for a fast read, which returns only the low 32 bits. The remaining 31 bits name the counter. A separate privileged write port loads any counter directly.

Top module: `evc_bank_rd`

## Requirements
- R1: After reset every counter holds zero and `rsp_valid`, `rsp_gp`, `rsp_ud`, `rsp_lo` and `rsp_hi` are all zero.
- R2: A counter adds one on each clock edge at which its `evt_in` bit is high. It wraps to zero after its maximum: 2^40-1 for indices 0..17 and 2^32-1 for indices 18..25.
- R3: When `wr_en` is high with `wr_idx` in 0..25, that counter takes `wr_data` at the clock edge, truncated to the counter's width. This overrides an event increment in the same cycle.
- R4: A full read (`rd_sel[31]`=0) of a counter in 0..17 returns counter bits 31:0 in `rsp_lo` and counter bits 39:32 in `rsp_hi[7:0]`, with `rsp_hi[31:8]` zero.
- R5: A fast read (`rd_sel[31]`=1) of a counter in 0..17 returns counter bits 31:0 in `rsp_lo` and zero in `rsp_hi`.
- R6: A read of a counter in 18..25 returns its 32-bit value in `rsp_lo` and zero in `rsp_hi`, in either read mode.
- R7: A read is allowed when `ctx_user_rd_en`=1, or `ctx_cpl`=0, or `ctx_prot_en`=0. Otherwise it gives `rsp_gp`=1.
- R8: A read whose `rd_sel[30:0]` is greater than 25 gives `rsp_gp`=1. This includes any nonzero bit among 30:5.
- R9: A request with `rd_lock`=1 gives `rsp_ud`=1 and `rsp_gp`=0, whatever the select word and privilege context. The two fault outputs are never high together.
- R10: `rsp_valid` is high exactly in the cycle after a cycle with `rd_req`=1. In every faulted or idle response, `rsp_lo` and `rsp_hi` are zero.
- R11: A read returns the counter value from before the clock edge that samples the request. An increment or a write in that same cycle shows only in later reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 26 | One event line per counter |
| wr_en | input | 1 | Privileged counter load strobe |
| wr_idx | input | 5 | Index of the counter to load |
| wr_data | input | 40 | Load value, truncated for 32-bit counters |
| rd_req | input | 1 | Read request strobe |
| rd_sel | input | 32 | Bit 31 selects fast mode; bits 30:0 hold the counter index |
| rd_lock | input | 1 | Request carries a lock prefix |
| ctx_cpl | input | 2 | Current privilege level of the requester |
| ctx_prot_en | input | 1 | Protection mode active |
| ctx_user_rd_en | input | 1 | User-level counter reads enabled |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_lo | output | 32 | Low result word |
| rsp_hi | output | 32 | High result word |
| rsp_gp | output | 1 | General-protection fault |
| rsp_ud | output | 1 | Invalid-opcode fault |

## Verification
A read can land in the same cycle as an update of the counter it names, either an event increment or a write on the load port, and the write can itself collide with an increment. The bench provokes this by driving `rd_req`, `wr_en` and the counter's `evt_in` bit at the same falling edge. The read must return the old value and the counter must end up holding the written data, not data plus one; a second read confirms this. A separate case loads a counter while its event line is high and expects exactly the loaded value afterwards.

// File: rtl/evc_pkg.sv
package evc_pkg;

  typedef struct packed {
    logic [31:0] hi;
    logic [31:0] lo;
  } evc_word_t;

  // Three-way permission rule for counter reads.
  function automatic logic evc_read_allowed(input logic [1:0] cpl,
                                            input logic       prot_on,
                                            input logic       user_ok);
    return user_ok || (cpl == 2'd0) || !prot_on;
  endfunction

  // True when the 31-bit index names an existing counter.
  function automatic logic evc_index_ok(input logic [30:0] idx,
                                        input int unsigned count);
    logic [31:0] ext;
    ext = {1'b0, idx};
    return ext < count;
  endfunction

  // Splits a zero-extended counter value into the two result words.
  function automatic evc_word_t evc_shape(input logic [63:0] raw,
                                          input logic        wide,
                                          input logic        fast);
    evc_word_t w;
    w.lo = raw[31:0];
    w.hi = (wide && !fast) ? raw[63:32] : 32'd0;
    return w;
  endfunction

endpackage

// File: rtl/evc_counter.sv
module evc_counter #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bump,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] value
);

  always_ff @(posedge clk) begin
    if (!rst_n)    value <= '0;
    else if (load) value <= load_val;
    else if (bump) value <= value + W'(1);
  end

endmodule

// File: rtl/evc_read_decode.sv
module evc_read_decode
  import evc_pkg::*;
#(
  parameter int NUM      = 26,
  parameter int NUM_WIDE = 18,
  parameter int WIDE_W   = 40,
  parameter int IDX_W    = 5
) (
  input  logic [NUM-1:0][WIDE_W-1:0] cnt_view,
  input  logic [31:0]                sel,
  input  logic                       lock,
  input  logic [1:0]                 cpl,
  input  logic                       prot_on,
  input  logic                       user_ok,
  output evc_word_t                  word,
  output logic                       gp,
  output logic                       ud,
  output logic                       idx_ok,
  output logic                       allowed
);

  logic [IDX_W-1:0]  idx;
  logic [WIDE_W-1:0] chosen;
  logic              wide;
  logic              fast;
  logic              fault;

  assign idx     = sel[IDX_W-1:0];
  assign fast    = sel[31];
  assign idx_ok  = evc_index_ok(sel[30:0], NUM);
  assign allowed = evc_read_allowed(cpl, prot_on, user_ok);
  assign wide    = idx_ok && (int'(idx) < NUM_WIDE);

  always_comb begin
    chosen = '0;
    for (int i = 0; i < NUM; i++) begin
      if (idx == IDX_W'(i)) chosen = cnt_view[i];
    end
  end

  // Lock prefix outranks every other fault.
  assign ud    = lock;
  assign gp    = !lock && (!allowed || !idx_ok);
  assign fault = ud || gp;
  assign word  = fault ? '0 : evc_shape(64'(chosen), wide, fast);

endmodule

// File: rtl/evc_bank_rd.sv
module evc_bank_rd
  import evc_pkg::*;
#(
  parameter int NUM_WIDE   = 18,
  parameter int NUM_NARROW = 8,
  parameter int WIDE_W     = 40,
  parameter int NARROW_W   = 32,
  localparam int NUM       = NUM_WIDE + NUM_NARROW,
  localparam int IDX_W     = $clog2(NUM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM-1:0]    evt_in,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WIDE_W-1:0] wr_data,
  input  logic              rd_req,
  input  logic [31:0]       rd_sel,
  input  logic              rd_lock,
  input  logic [1:0]        ctx_cpl,
  input  logic              ctx_prot_en,
  input  logic              ctx_user_rd_en,
  output logic              rsp_valid,
  output logic [31:0]       rsp_lo,
  output logic [31:0]       rsp_hi,
  output logic              rsp_gp,
  output logic              rsp_ud
);

  // Named internal events, visible to the checker.
  logic [NUM-1:0]             cnt_load;
  logic [NUM-1:0]             cnt_bump;
  logic [NUM-1:0][WIDE_W-1:0] cnt_view;
  evc_word_t                  dec_word;
  logic                       dec_gp;
  logic                       dec_ud;
  logic                       dec_idx_ok;
  logic                       dec_allowed;

  assign cnt_bump = evt_in;

  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    assign cnt_load[g] = wr_en && (wr_idx == IDX_W'(g));
    if (g < NUM_WIDE) begin : g_wide
      evc_counter #(.W(WIDE_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .bump     (cnt_bump[g]),
        .load     (cnt_load[g]),
        .load_val (wr_data),
        .value    (cnt_view[g])
      );
    end else begin : g_narrow
      logic [NARROW_W-1:0] nval;
      evc_counter #(.W(NARROW_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .bump     (cnt_bump[g]),
        .load     (cnt_load[g]),
        .load_val (wr_data[NARROW_W-1:0]),
        .value    (nval)
      );
      assign cnt_view[g] = WIDE_W'(nval);
    end
  end

  evc_read_decode #(
    .NUM      (NUM),
    .NUM_WIDE (NUM_WIDE),
    .WIDE_W   (WIDE_W),
    .IDX_W    (IDX_W)
  ) u_dec (
    .cnt_view (cnt_view),
    .sel      (rd_sel),
    .lock     (rd_lock),
    .cpl      (ctx_cpl),
    .prot_on  (ctx_prot_en),
    .user_ok  (ctx_user_rd_en),
    .word     (dec_word),
    .gp       (dec_gp),
    .ud       (dec_ud),
    .idx_ok   (dec_idx_ok),
    .allowed  (dec_allowed)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_lo    <= '0;
      rsp_hi    <= '0;
      rsp_gp    <= 1'b0;
      rsp_ud    <= 1'b0;
    end else begin
      rsp_valid <= rd_req;
      rsp_lo    <= rd_req ? dec_word.lo : '0;
      rsp_hi    <= rd_req ? dec_word.hi : '0;
      rsp_gp    <= rd_req && dec_gp;
      rsp_ud    <= rd_req && dec_ud;
    end
  end

endmodule

// File: rtl/evc_bank_rd_chk.sv
module evc_bank_rd_chk #(
  parameter int NUM      = 26,
  parameter int NUM_WIDE = 18,
  parameter int WIDE_W   = 40,
  parameter int IDX_W    = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic [IDX_W-1:0]           wr_idx,
  input logic [WIDE_W-1:0]          wr_data,
  input logic                       rd_req,
  input logic [31:0]                rd_sel,
  input logic                       rd_lock,
  input logic [1:0]                 ctx_cpl,
  input logic                       ctx_prot_en,
  input logic                       ctx_user_rd_en,
  input logic                       rsp_valid,
  input logic [31:0]                rsp_lo,
  input logic [31:0]                rsp_hi,
  input logic                       rsp_gp,
  input logic                       rsp_ud,
  input logic [NUM-1:0][WIDE_W-1:0] cnt_view
);

  a_r10_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (!rsp_valid && !rsp_gp && !rsp_ud && rsp_lo == 32'd0 && rsp_hi == 32'd0));

  a_r10_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_gp || rsp_ud) |-> (rsp_lo == 32'd0 && rsp_hi == 32'd0));

  a_r9_single_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_gp && rsp_ud));

  a_r9_lock_ud: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_lock) |=> rsp_ud);

  a_r7_deny: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_lock && ctx_prot_en && ctx_cpl != 2'd0 && !ctx_user_rd_en) |=> rsp_gp);

  a_r8_bad_index: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_lock && rd_sel[30:0] >= 31'(NUM)) |=> rsp_gp);

  a_r5_fast_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_sel[31]) |=> rsp_hi == 32'd0);

  a_r6_narrow_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_sel[30:0] >= 31'(NUM_WIDE)) |=> rsp_hi == 32'd0);

  a_r4_hi_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hi >> (WIDE_W - 32)) == 32'd0);

  a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) < NUM) |=>
      cnt_view[$past(wr_idx)][31:0] == $past(wr_data[31:0]));

endmodule

bind evc_bank_rd evc_bank_rd_chk #(
  .NUM      (NUM),
  .NUM_WIDE (NUM_WIDE),
  .WIDE_W   (WIDE_W),
  .IDX_W    (IDX_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wr_en          (wr_en),
  .wr_idx         (wr_idx),
  .wr_data        (wr_data),
  .rd_req         (rd_req),
  .rd_sel         (rd_sel),
  .rd_lock        (rd_lock),
  .ctx_cpl        (ctx_cpl),
  .ctx_prot_en    (ctx_prot_en),
  .ctx_user_rd_en (ctx_user_rd_en),
  .rsp_valid      (rsp_valid),
  .rsp_lo         (rsp_lo),
  .rsp_hi         (rsp_hi),
  .rsp_gp         (rsp_gp),
  .rsp_ud         (rsp_ud),
  .cnt_view       (cnt_view)
);

// File: tb/evc_bank_rd_bench.sv
module evc_bank_rd_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [25:0] evt_in = '0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [39:0] wr_data = '0;
  logic        rd_req = 1'b0;
  logic [31:0] rd_sel = '0;
  logic        rd_lock = 1'b0;
  logic [1:0]  ctx_cpl = 2'd0;
  logic        ctx_prot_en = 1'b0;
  logic        ctx_user_rd_en = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_lo;
  logic [31:0] rsp_hi;
  logic        rsp_gp;
  logic        rsp_ud;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] o_lo, o_hi;
  logic        o_gp, o_ud, o_valid;

  always #5 clk = ~clk;

  evc_bank_rd u_evc_bank_rd (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_req(rd_req), .rd_sel(rd_sel), .rd_lock(rd_lock),
    .ctx_cpl(ctx_cpl), .ctx_prot_en(ctx_prot_en), .ctx_user_rd_en(ctx_user_rd_en),
    .rsp_valid(rsp_valid), .rsp_lo(rsp_lo), .rsp_hi(rsp_hi),
    .rsp_gp(rsp_gp), .rsp_ud(rsp_ud)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Read with an explicit context; results land in o_*.
  task automatic rd(input logic [31:0] sel, input logic lock, input logic [1:0] cpl,
                    input logic prot, input logic user);
    @(negedge clk);
    rd_req = 1'b1; rd_sel = sel; rd_lock = lock;
    ctx_cpl = cpl; ctx_prot_en = prot; ctx_user_rd_en = user;
    @(negedge clk);
    rd_req = 1'b0; rd_lock = 1'b0;
    o_lo = rsp_lo; o_hi = rsp_hi; o_gp = rsp_gp; o_ud = rsp_ud; o_valid = rsp_valid;
  endtask

  task automatic rd_priv(input logic [31:0] sel);
    rd(sel, 1'b0, 2'd0, 1'b1, 1'b0);
  endtask

  task automatic wr(input int idx, input logic [39:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int idx, input int n);
    @(negedge clk);
    evt_in[idx] = 1'b1;
    repeat (n) @(negedge clk);
    evt_in[idx] = 1'b0;
  endtask

  task automatic t_reset;
    chk(rsp_valid == 1'b0 && rsp_gp == 1'b0 && rsp_ud == 1'b0, "R1 idle after reset",
        64'({rsp_valid, rsp_gp, rsp_ud}), 64'd0);
    rd_priv(32'd0);
    chk(o_lo == 0 && o_hi == 0 && o_valid, "R1 counter 0 reads zero", {o_hi, o_lo}, 64'd0);
    rd_priv(32'd25);
    chk(o_lo == 0 && o_hi == 0, "R1 counter 25 reads zero", {o_hi, o_lo}, 64'd0);
  endtask

  task automatic t_count;
    pulse(3, 5);
    rd_priv(32'd3);
    chk(o_lo == 32'd5 && o_hi == 0, "R2 wide counter counts 5", {o_hi, o_lo}, 64'd5);
    pulse(20, 7);
    rd_priv(32'd20);
    chk(o_lo == 32'd7 && o_hi == 0, "R2 narrow counter counts 7", {o_hi, o_lo}, 64'd7);
  endtask

  task automatic t_wide_reads;
    wr(4, 40'hAB_1234_5678);
    rd_priv(32'd4);
    chk(o_lo == 32'h1234_5678 && o_hi == 32'h0000_00AB, "R4 full read split",
        {o_hi, o_lo}, 64'h0000_00AB_1234_5678);
    rd_priv(32'h8000_0004);
    chk(o_lo == 32'h1234_5678 && o_hi == 0, "R5 fast read high zero",
        {o_hi, o_lo}, 64'h0000_0000_1234_5678);
    wr(2, 40'hFF_FFFF_FFFE);
    pulse(2, 3);
    rd_priv(32'd2);
    chk(o_lo == 32'd1 && o_hi == 0, "R2 wide wrap at 40 bits", {o_hi, o_lo}, 64'd1);
  endtask

  task automatic t_narrow;
    wr(25, 40'h12_FFFF_FFFF);
    rd_priv(32'd25);
    chk(o_lo == 32'hFFFF_FFFF && o_hi == 0, "R6 narrow full read truncated",
        {o_hi, o_lo}, 64'h0000_0000_FFFF_FFFF);
    rd_priv(32'h8000_0019);
    chk(o_lo == 32'hFFFF_FFFF && o_hi == 0, "R6 narrow fast read",
        {o_hi, o_lo}, 64'h0000_0000_FFFF_FFFF);
    pulse(25, 1);
    rd_priv(32'd25);
    chk(o_lo == 0 && o_hi == 0, "R2 narrow wrap at 32 bits", {o_hi, o_lo}, 64'd0);
  endtask

  task automatic t_write_priority;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd5; wr_data = 40'd100; evt_in[5] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; evt_in[5] = 1'b0;
    rd_priv(32'd5);
    chk(o_lo == 32'd100, "R3 write beats increment", 64'(o_lo), 64'd100);
  endtask

  task automatic t_same_cycle;
    wr(6, 40'd50);
    @(negedge clk);
    rd_req = 1'b1; rd_sel = 32'd6; ctx_cpl = 2'd0; ctx_prot_en = 1'b1; ctx_user_rd_en = 1'b0;
    wr_en = 1'b1; wr_idx = 5'd6; wr_data = 40'd999; evt_in[6] = 1'b1;
    @(negedge clk);
    rd_req = 1'b0; wr_en = 1'b0; evt_in[6] = 1'b0;
    chk(rsp_valid && rsp_lo == 32'd50, "R11 read sees pre-write value", 64'(rsp_lo), 64'd50);
    rd_priv(32'd6);
    chk(o_lo == 32'd999, "R3 R11 written value after collision", 64'(o_lo), 64'd999);
    wr(7, 40'd10);
    @(negedge clk);
    rd_req = 1'b1; rd_sel = 32'd7; evt_in[7] = 1'b1;
    @(negedge clk);
    rd_req = 1'b0; evt_in[7] = 1'b0;
    chk(rsp_lo == 32'd10, "R11 read sees pre-increment value", 64'(rsp_lo), 64'd10);
    rd_priv(32'd7);
    chk(o_lo == 32'd11, "R11 increment lands afterwards", 64'(o_lo), 64'd11);
  endtask

  task automatic t_perm;
    rd(32'd4, 1'b0, 2'd3, 1'b1, 1'b0);
    chk(o_gp && !o_ud && o_lo == 0 && o_hi == 0, "R7 R10 user read denied",
        {o_hi, o_lo[29:0], o_gp, o_ud}, 64'd2);
    rd(32'd4, 1'b0, 2'd3, 1'b1, 1'b1);
    chk(!o_gp && o_lo == 32'h1234_5678, "R7 user enable allows", 64'(o_lo), 64'h1234_5678);
    rd(32'd4, 1'b0, 2'd3, 1'b0, 1'b0);
    chk(!o_gp && o_lo == 32'h1234_5678, "R7 protection off allows", 64'(o_lo), 64'h1234_5678);
    rd(32'd4, 1'b0, 2'd0, 1'b1, 1'b0);
    chk(!o_gp && o_hi == 32'hAB, "R7 level 0 allows", 64'(o_hi), 64'hAB);
  endtask

  task automatic t_index;
    rd_priv(32'd26);
    chk(o_gp && o_lo == 0, "R8 index 26 faults", 64'(o_gp), 64'd1);
    rd_priv(32'h8000_001A);
    chk(o_gp && o_hi == 0, "R8 fast index 26 faults", 64'(o_gp), 64'd1);
    rd_priv(32'h4000_0004);
    chk(o_gp && o_lo == 0, "R8 high index bits fault", 64'(o_gp), 64'd1);
  endtask

  task automatic t_lock;
    rd(32'd4, 1'b1, 2'd0, 1'b1, 1'b0);
    chk(o_ud && !o_gp && o_lo == 0 && o_hi == 0, "R9 lock gives invalid opcode",
        64'({o_ud, o_gp}), 64'd2);
    rd(32'd30, 1'b1, 2'd3, 1'b1, 1'b0);
    chk(o_ud && !o_gp, "R9 lock outranks protection fault", 64'({o_ud, o_gp}), 64'd2);
  endtask

  task automatic t_valid;
    rd_priv(32'd3);
    @(negedge clk);
    chk(!rsp_valid && rsp_lo == 0, "R10 valid lasts one cycle", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_wide_reads();
    t_narrow();
    t_write_priority();
    t_same_cycle();
    t_perm();
    t_index();
    t_lock();
    t_valid();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule